// File: doc/BRIEF.md
# Power Button Sleep-State Controller

This block sits between an active-low push-button pin and the platform's sleep-state logic. The raw pin is first brought into the clock domain. It is then filtered, so that a new level is taken only after it has stayed unchanged for a set number of slow reference ticks. The filtered level is shown on a status bit. The moment the filtered level turns to "pressed", the block looks at the current system state. When the system is running, it raises a software interrupt, either the system-management kind or the ACPI kind, as chosen by a routing select bit. When the system is asleep, it raises a wake request. When the system is unpowered, nothing happens.

A second path watches how long the button is held. While the system is in the running state and the filtered button stays pressed, a timer counts reference ticks. When it reaches the hold limit, the block pulses a forced-soft-off request. That request needs no acknowledge from the processor or from anything else. Leaving the running state clears the timer, and so does releasing the button. A press that wakes the system therefore starts its hold count only once the system is back in the running state.

Both intervals count a slow tick input. The tick counts are parameters, so the same block serves silicon-length intervals (16 ms, 4 s) and short simulation values.

Top module: `pwrkey_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, smi_pulse, sci_pulse, wake_pulse, force_off_pulse and btn_lvl are all 0.
- R2: The filtered level changes only after the synchronised input has differed from it for DEB_TICKS consecutive ticks. A pulse shorter than that interval changes nothing and raises no event.
- R3: btn_lvl is 1 while the filtered button is pressed (btn_n low) and 0 while it is released.
- R4: With sys_state = 0 (running) and sci_sel = 0, a filtered press gives exactly one smi_pulse and no sci_pulse.
- R5: With sys_state = 0 and sci_sel = 1, a filtered press gives exactly one sci_pulse and no smi_pulse.
- R6: With sys_state from 1 to 5 (sleep states), a filtered press gives exactly one wake_pulse and no interrupt.
- R7: With sys_state = 7 (unpowered) or the unused code 6, a press gives no pulse of any kind. Such a press is not remembered, so a later change to state 0 while the button is still held gives no interrupt.
- R8: A filtered release gives no smi, sci or wake pulse.
- R9: A press held in state 0 for HOLD_TICKS ticks gives exactly one force_off_pulse, however much longer the button is held.
- R10: The hold timer counts only in state 0 and is cleared in every other state. A press held through a sleep state gives no force-off there and needs a full HOLD_TICKS in state 0 afterwards.
- R11: A release clears the hold timer, so two presses that are each shorter than the hold limit give no force-off.
- R12: Every output pulse lasts one cycle, and at most one of smi_pulse, sci_pulse and wake_pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow reference tick, one clock wide |
| btn_n | input | 1 | Raw power-button pin, low when pressed |
| sys_state | input | 3 | Current state: 0 running, 1-5 sleep, 7 unpowered |
| sci_sel | input | 1 | Interrupt routing: 0 SMI, 1 SCI |
| smi_pulse | output | 1 | System-management interrupt request |
| sci_pulse | output | 1 | ACPI interrupt request |
| wake_pulse | output | 1 | Wake request to return to running state |
| force_off_pulse | output | 1 | Unconditional request to go to soft-off |
| btn_lvl | output | 1 | Filtered button level, 1 = pressed |

## Verification
A debounce counter that is not restarted would show as a btn_lvl change and an event after a train of short glitches. The bench sees that within one debounce interval of the last glitch. A hold timer that keeps counting outside the running state, or survives a release, shows up early: a force_off_pulse arrives less than HOLD_TICKS ticks after the system enters state 0 or after the second press. A stuck edge detector or state decode shows up one cycle after the level changes, as a missing pulse, a doubled pulse or a pulse on the wrong output.

// File: rtl/pwrkey_pkg.sv
package pwrkey_pkg;

    typedef enum logic [2:0] {
        ST_RUN  = 3'd0,
        ST_SL1  = 3'd1,
        ST_SL2  = 3'd2,
        ST_SL3  = 3'd3,
        ST_SL4  = 3'd4,
        ST_SOFF = 3'd5,
        ST_RSVD = 3'd6,
        ST_NOPWR = 3'd7
    } sys_state_e;

    typedef struct packed {
        logic smi;
        logic sci;
        logic wake;
    } key_evt_t;

    function automatic logic state_is_run(input logic [2:0] s);
        return s == ST_RUN;
    endfunction

    function automatic logic state_is_sleep(input logic [2:0] s);
        return (s >= ST_SL1) && (s <= ST_SOFF);
    endfunction

endpackage

// File: rtl/pwrkey_debounce.sv
module pwrkey_debounce #(
    parameter int DEB_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw_n,
    output logic level
);
    localparam int CW = $clog2(DEB_TICKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   pressed_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= raw_n;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
            end
        end
    endgenerate

    assign pressed_s = ~sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
            cnt_q <= '0;
        end else if (pressed_s == level) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == CW'(DEB_TICKS - 1)) begin
                level <= pressed_s;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrkey_hold_timer.sv
module pwrkey_hold_timer #(
    parameter int HOLD_TICKS = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    input  logic running,
    output logic fire
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] cnt_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            fire   <= 1'b0;
        end else if (!level || !running) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
            fire   <= 1'b0;
        end else if (tick && !done_q) begin
            if (cnt_q == HW'(HOLD_TICKS - 1)) begin
                done_q <= 1'b1;
                fire   <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                fire  <= 1'b0;
            end
        end else begin
            fire <= 1'b0;
        end
    end
endmodule

// File: rtl/pwrkey_evt_route.sv
module pwrkey_evt_route
    import pwrkey_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  logic [2:0] sys_state,
    input  logic       sci_sel,
    output key_evt_t   evt
);
    logic     level_d;
    logic     press_edge;
    key_evt_t evt_n;

    assign press_edge = level & ~level_d;

    always_comb begin
        evt_n      = '0;
        evt_n.smi  = press_edge & state_is_run(sys_state) & ~sci_sel;
        evt_n.sci  = press_edge & state_is_run(sys_state) & sci_sel;
        evt_n.wake = press_edge & state_is_sleep(sys_state);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_d <= 1'b0;
            evt     <= '0;
        end else begin
            level_d <= level;
            evt     <= evt_n;
        end
    end
endmodule

// File: rtl/pwrkey_ctrl.sv
module pwrkey_ctrl
    import pwrkey_pkg::*;
#(
    parameter int DEB_TICKS   = 16,
    parameter int HOLD_TICKS  = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       btn_n,
    input  logic [2:0] sys_state,
    input  logic       sci_sel,
    output logic       smi_pulse,
    output logic       sci_pulse,
    output logic       wake_pulse,
    output logic       force_off_pulse,
    output logic       btn_lvl
);
    logic     level;
    key_evt_t evt;

    pwrkey_debounce #(
        .DEB_TICKS  (DEB_TICKS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_deb (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .raw_n(btn_n),
        .level(level)
    );

    pwrkey_evt_route u_route (
        .clk      (clk),
        .rst      (rst),
        .level    (level),
        .sys_state(sys_state),
        .sci_sel  (sci_sel),
        .evt      (evt)
    );

    pwrkey_hold_timer #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .level  (level),
        .running(state_is_run(sys_state)),
        .fire   (force_off_pulse)
    );

    assign smi_pulse  = evt.smi;
    assign sci_pulse  = evt.sci;
    assign wake_pulse = evt.wake;
    assign btn_lvl    = level;
endmodule

// File: rtl/pwrkey_ctrl_chk.sv
module pwrkey_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic [2:0] sys_state,
    input logic       sci_sel,
    input logic       smi_pulse,
    input logic       sci_pulse,
    input logic       wake_pulse,
    input logic       force_off_pulse,
    input logic       btn_lvl
);
    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(smi_pulse || sci_pulse || wake_pulse || force_off_pulse || btn_lvl)); // R1

    AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(btn_lvl)) |-> $past(tick)); // R2

    AST_SMI_ROUTE: assert property (@(posedge clk) disable iff (rst)
        smi_pulse |-> ($past(sys_state) == 3'd0 && !$past(sci_sel) && $past(btn_lvl))); // R4

    AST_SCI_ROUTE: assert property (@(posedge clk) disable iff (rst)
        sci_pulse |-> ($past(sys_state) == 3'd0 && $past(sci_sel) && $past(btn_lvl))); // R5

    AST_WAKE_SLEEP: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> ($past(sys_state) >= 3'd1 && $past(sys_state) <= 3'd5)); // R6

    AST_NOPWR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(sys_state) >= 3'd6) |-> !(smi_pulse || sci_pulse || wake_pulse)); // R7

    AST_FORCE_RUN: assert property (@(posedge clk) disable iff (rst)
        force_off_pulse |-> ($past(sys_state) == 3'd0 && $past(btn_lvl))); // R10

    AST_EVT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smi_pulse, sci_pulse, wake_pulse})); // R12

    AST_FORCE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        force_off_pulse |=> !force_off_pulse); // R12

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (smi_pulse || sci_pulse || wake_pulse) |=> !(smi_pulse || sci_pulse || wake_pulse)); // R12
endmodule

bind pwrkey_ctrl pwrkey_ctrl_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .tick           (tick),
    .sys_state      (sys_state),
    .sci_sel        (sci_sel),
    .smi_pulse      (smi_pulse),
    .sci_pulse      (sci_pulse),
    .wake_pulse     (wake_pulse),
    .force_off_pulse(force_off_pulse),
    .btn_lvl        (btn_lvl)
);

// File: tb/pwrkey_ctrl_tb.sv
`timescale 1ns/1ps
module pwrkey_ctrl_tb;
    localparam int DEB  = 4;
    localparam int HOLD = 25;

    logic clk = 0, rst = 1, tick = 0, btn_n = 1, sci_sel = 0;
    logic [2:0] sys_state = 3'd0;
    logic smi_pulse, sci_pulse, wake_pulse, force_off_pulse, btn_lvl;

    int checks = 0, errors = 0;
    int n_smi = 0, n_sci = 0, n_wake = 0, n_off = 0;
    int div = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        div  <= (div == 3) ? 0 : div + 1;
        tick <= (div == 3);
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (smi_pulse)       n_smi++;
            if (sci_pulse)       n_sci++;
            if (wake_pulse)      n_wake++;
            if (force_off_pulse) n_off++;
        end
    end

    pwrkey_ctrl #(.DEB_TICKS(DEB), .HOLD_TICKS(HOLD)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n),
        .sys_state(sys_state), .sci_sel(sci_sel),
        .smi_pulse(smi_pulse), .sci_pulse(sci_pulse), .wake_pulse(wake_pulse),
        .force_off_pulse(force_off_pulse), .btn_lvl(btn_lvl)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_counts();
        n_smi = 0; n_sci = 0; n_wake = 0; n_off = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 btn_lvl in reset", btn_lvl, 0);
        chk("R1 pulses in reset", smi_pulse + sci_pulse + wake_pulse + force_off_pulse, 0);
        rst = 0;
        wait_clk(1);
        chk("R1 outputs after reset", btn_lvl + smi_pulse + sci_pulse + wake_pulse + force_off_pulse, 0);
    endtask

    task automatic t_glitch();
        clear_counts();
        sys_state = 3'd0; sci_sel = 0;
        for (int i = 0; i < 5; i++) begin
            btn_n = 0; wait_clk(8);
            btn_n = 1; wait_clk(8);
        end
        wait_clk(30);
        chk("R2 glitches leave level", btn_lvl, 0);
        chk("R2 glitches raise no event", n_smi + n_sci + n_wake + n_off, 0);
    endtask

    task automatic t_run_smi();
        clear_counts();
        sys_state = 3'd0; sci_sel = 0;
        btn_n = 0; wait_clk(40);
        chk("R3 level pressed", btn_lvl, 1);
        chk("R4 one smi", n_smi, 1);
        chk("R4 no sci", n_sci, 0);
        btn_n = 1; wait_clk(40);
        chk("R3 level released", btn_lvl, 0);
        chk("R8 release no event", n_smi + n_sci + n_wake, 1);
        chk("R11 short press no force", n_off, 0);
    endtask

    task automatic t_run_sci();
        clear_counts();
        sys_state = 3'd0; sci_sel = 1;
        btn_n = 0; wait_clk(40);
        chk("R5 one sci", n_sci, 1);
        chk("R5 no smi", n_smi, 0);
        btn_n = 1; wait_clk(40);
        sci_sel = 0;
    endtask

    task automatic t_sleep_wake();
        clear_counts();
        sys_state = 3'd3;
        btn_n = 0; wait_clk(40);
        chk("R6 one wake", n_wake, 1);
        chk("R6 no interrupt", n_smi + n_sci, 0);
        wait_clk(200);
        chk("R10 no force while asleep", n_off, 0);
        sys_state = 3'd0; wait_clk(80);
        chk("R10 timer restarted in run", n_off, 0);
        wait_clk(60);
        chk("R10 force after full hold in run", n_off, 1);
        chk("R7 no smi on entry to run", n_smi, 0);
        btn_n = 1; wait_clk(40);
    endtask

    task automatic t_other_sleep_states();
        for (int s = 1; s <= 5; s++) begin
            clear_counts();
            sys_state = 3'(s);
            btn_n = 0; wait_clk(40);
            btn_n = 1; wait_clk(40);
            chk($sformatf("R6 wake in state %0d", s), n_wake, 1);
        end
        sys_state = 3'd0;
    endtask

    task automatic t_nopwr();
        clear_counts();
        sys_state = 3'd7;
        btn_n = 0; wait_clk(40);
        chk("R7 no pulse unpowered", n_smi + n_sci + n_wake + n_off, 0);
        sys_state = 3'd0; wait_clk(60);
        chk("R7 press not remembered", n_smi + n_sci + n_wake, 0);
        btn_n = 1; wait_clk(40);
        sys_state = 3'd6;
        btn_n = 0; wait_clk(40);
        btn_n = 1; wait_clk(40);
        chk("R7 no pulse in code 6", n_smi + n_sci + n_wake + n_off, 0);
        sys_state = 3'd0;
    endtask

    task automatic t_hold();
        clear_counts();
        sys_state = 3'd0;
        btn_n = 0; wait_clk(100);
        chk("R9 no force before limit", n_off, 0);
        wait_clk(40);
        chk("R9 force at limit", n_off, 1);
        wait_clk(300);
        chk("R9 single force per hold", n_off, 1);
        btn_n = 1; wait_clk(40);
    endtask

    task automatic t_release_clears();
        clear_counts();
        sys_state = 3'd0;
        btn_n = 0; wait_clk(90);
        btn_n = 1; wait_clk(40);
        btn_n = 0; wait_clk(90);
        chk("R11 release clears timer", n_off, 0);
        chk("R12 two presses two smi", n_smi, 2);
        btn_n = 1; wait_clk(40);
    endtask

    initial begin
        fork
            begin
                wait_clk(3);
                t_reset();
                t_glitch();
                t_run_smi();
                t_run_sci();
                t_sleep_wake();
                t_other_sleep_states();
                t_nopwr();
                t_hold();
                t_release_clears();
                done = 1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog actual=timeout expected=finish");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule